// File: doc/BRIEF.md
# VLAN Violation Capture Unit

This unit sits next to the VLAN table and watches each per-frame lookup result: the ingress port, the frame's VID, whether the table held a valid entry for that VID, and the ingress port's 2-bit membership code for that VLAN. When a frame breaks VLAN policy it records the first such event and holds it. It keeps an interrupt line raised for as long as a record is held. A frame whose VID has no valid table entry is a miss violation. A frame whose VID is in the table but whose ingress port is not a member of it is a member violation.

Software services the interrupt with a single get-and-clear command. It pulses `cmd_go`, waits until `cmd_busy` drops, and then reads two result registers. The command result register carries the offending port in bits [3:0], the miss flag in bit 5 and the member flag in bit 6. The VID result register carries the offending VID. Completing the command empties the record and arms capture again.

The command sequencer has three states. `ST_IDLE` moves to `ST_EXEC` when `cmd_go` is sampled. `ST_EXEC` counts `EXEC_CYCLES` cycles and then moves to `ST_REPORT`. `ST_REPORT` always returns to `ST_IDLE`. On the edge that leaves `ST_REPORT`, the result registers are loaded and the record is cleared.

Top module: `vlan_viol_capture`

## Requirements
- R1: A valid lookup with the hit flag low is captured as a miss violation. The next get-and-clear returns command result bit 5 = 1, bit 6 = 0, the port in bits [3:0], and the frame's VID in the VID result.
- R2: A valid lookup with the hit flag high and membership code 3 is captured as a member violation. Get-and-clear returns bit 6 = 1, bit 5 = 0, the port in bits [3:0], and the VID in the VID result.
- R3: A valid lookup with the hit flag high and membership code 0, 1 or 2 is not a violation and leaves the interrupt low.
- R4: Only the first violation is held. Any violation that arrives while a record is pending is dropped and does not alter the port, the VID or the kind that are later reported.
- R5: `irq` rises in the cycle after a violation is captured. It stays high until the get-and-clear that empties the record completes.
- R6: `cmd_busy` rises in the cycle after `cmd_go` is sampled in `ST_IDLE`. It stays high for exactly `EXEC_CYCLES`+1 cycles. Both result registers hold their new values in the first cycle after `cmd_busy` falls.
- R7: A get-and-clear issued with no violation pending returns a command result of 0 (both flags clear, port 0) and leaves the VID result unchanged.
- R8: `cmd_go` asserted while `cmd_busy` is high is ignored. No second command follows.
- R9: A violation that arrives in the last busy cycle of a get-and-clear (`ST_REPORT`) is captured into the freshly emptied record. The command still reports the older record, `irq` stays high, and the next command reports the new violation.
- R10: A lookup presented with `lk_valid` low is never captured, whatever the other lookup inputs are.
- R11: After reset, `irq` and `cmd_busy` are low, and both result registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup result present this cycle |
| lk_port | input | 4 | Ingress port of the frame |
| lk_vid | input | 12 | VID of the frame |
| lk_hit | input | 1 | Table held a valid entry for the VID |
| lk_memb | input | 2 | Membership code of the ingress port (3 = not a member) |
| cmd_go | input | 1 | One-cycle request for get-and-clear |
| cmd_busy | output | 1 | Command in progress |
| cmd_result | output | 16 | Port [3:0], miss flag [5], member flag [6], other bits 0 |
| vid_result | output | 12 | VID of the reported violation |
| irq | output | 1 | Violation pending |

## Verification
Two functions can land on the same clock edge: a new violation being captured, and the clear performed by a finishing get-and-clear. The bench provokes this by counting busy cycles from its own `cmd_go` and presenting a miss violation exactly in the `ST_REPORT` cycle. It then checks three things. The finishing command must return the older record. `irq` must stay high afterwards. A following command must return the colliding frame's port and VID. Randomly interleaved lookups and commands exercise the first-only drop rule around these clears.

// File: rtl/vlan_viol_pkg.sv
package vlan_viol_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_REPORT = 2'd2
    } cmd_state_e;

    typedef enum logic [1:0] {
        VK_NONE   = 2'd0,
        VK_MISS   = 2'd1,
        VK_MEMBER = 2'd2
    } viol_kind_e;

endpackage

// File: rtl/vvc_classify.sv
module vvc_classify
    import vlan_viol_pkg::*;
#(
    parameter int MEMB_W         = 2,
    parameter int NONMEMBER_CODE = 3
) (
    input  logic              lk_valid,
    input  logic              lk_hit,
    input  logic [MEMB_W-1:0] lk_memb,
    output viol_kind_e        kind
);

    localparam logic [MEMB_W-1:0] NONMEMB = MEMB_W'(NONMEMBER_CODE);

    always_comb begin
        kind = VK_NONE;
        if (lk_valid) begin
            if (!lk_hit)
                kind = VK_MISS;
            else if (lk_memb == NONMEMB)
                kind = VK_MEMBER;
        end
    end

endmodule

// File: rtl/vvc_record.sv
module vvc_record
    import vlan_viol_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int VID_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  viol_kind_e        det_kind,
    input  logic [PORT_W-1:0] det_port,
    input  logic [VID_W-1:0]  det_vid,
    input  logic              clr,
    output logic              rec_valid,
    output viol_kind_e        rec_kind,
    output logic [PORT_W-1:0] rec_port,
    output logic [VID_W-1:0]  rec_vid
);

    logic take;

    // capture when empty, or when being emptied on this very edge
    assign take = (det_kind != VK_NONE) && (!rec_valid || clr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_kind  <= VK_NONE;
            rec_port  <= '0;
            rec_vid   <= '0;
        end else begin
            if (clr)
                rec_valid <= 1'b0;
            if (take) begin
                rec_valid <= 1'b1;
                rec_kind  <= det_kind;
                rec_port  <= det_port;
                rec_vid   <= det_vid;
            end
        end
    end

endmodule

// File: rtl/vvc_cmd_fsm.sv
module vvc_cmd_fsm
    import vlan_viol_pkg::*;
#(
    parameter int EXEC_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_go,
    output logic busy,
    output logic report
);

    localparam int CNT_W = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXEC_CYCLES - 1);

    cmd_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cmd_go) state_nx = ST_EXEC;
            ST_EXEC:   if (cnt == '0) state_nx = ST_REPORT;
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cmd_go)
                cnt <= CNT_LOAD;
            else if (state == ST_EXEC && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        busy   = 1'b0;
        report = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_EXEC:   busy = 1'b1;
            ST_REPORT: begin
                busy   = 1'b1;
                report = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
    import vlan_viol_pkg::*;
#(
    parameter int PORT_W         = 4,
    parameter int VID_W          = 12,
    parameter int MEMB_W         = 2,
    parameter int NONMEMBER_CODE = 3,
    parameter int CMD_W          = 16,
    parameter int MISS_BIT       = 5,
    parameter int MEMB_BIT       = 6,
    parameter int EXEC_CYCLES    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PORT_W-1:0] lk_port,
    input  logic [VID_W-1:0]  lk_vid,
    input  logic              lk_hit,
    input  logic [MEMB_W-1:0] lk_memb,
    input  logic              cmd_go,
    output logic              cmd_busy,
    output logic [CMD_W-1:0]  cmd_result,
    output logic [VID_W-1:0]  vid_result,
    output logic              irq
);

    viol_kind_e        det_kind;
    logic              rec_valid;
    viol_kind_e        rec_kind;
    logic [PORT_W-1:0] rec_port;
    logic [VID_W-1:0]  rec_vid;
    logic              report;
    logic [CMD_W-1:0]  res_nx;

    vvc_classify #(
        .MEMB_W        (MEMB_W),
        .NONMEMBER_CODE(NONMEMBER_CODE)
    ) u_classify (
        .lk_valid(lk_valid),
        .lk_hit  (lk_hit),
        .lk_memb (lk_memb),
        .kind    (det_kind)
    );

    vvc_record #(
        .PORT_W(PORT_W),
        .VID_W (VID_W)
    ) u_record (
        .clk      (clk),
        .rst_n    (rst_n),
        .det_kind (det_kind),
        .det_port (lk_port),
        .det_vid  (lk_vid),
        .clr      (report),
        .rec_valid(rec_valid),
        .rec_kind (rec_kind),
        .rec_port (rec_port),
        .rec_vid  (rec_vid)
    );

    vvc_cmd_fsm #(
        .EXEC_CYCLES(EXEC_CYCLES)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_go(cmd_go),
        .busy  (cmd_busy),
        .report(report)
    );

    // pack the reported record into the command result layout
    always_comb begin
        res_nx = '0;
        if (rec_valid) begin
            res_nx[PORT_W-1:0] = rec_port;
            res_nx[MISS_BIT]   = (rec_kind == VK_MISS);
            res_nx[MEMB_BIT]   = (rec_kind == VK_MEMBER);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_result <= '0;
            vid_result <= '0;
        end else if (report) begin
            cmd_result <= res_nx;
            if (rec_valid)
                vid_result <= rec_vid;
        end
    end

    assign irq = rec_valid;

endmodule

// File: rtl/vvc_chk.sv
module vvc_chk #(
    parameter int MEMB_W         = 2,
    parameter int NONMEMBER_CODE = 3,
    parameter int CMD_W          = 16,
    parameter int VID_W          = 12,
    parameter int MISS_BIT       = 5,
    parameter int MEMB_BIT       = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_hit,
    input logic [MEMB_W-1:0] lk_memb,
    input logic              cmd_go,
    input logic              cmd_busy,
    input logic [CMD_W-1:0]  cmd_result,
    input logic [VID_W-1:0]  vid_result,
    input logic              irq
);

    localparam logic [MEMB_W-1:0] NONMEMB = MEMB_W'(NONMEMBER_CODE);

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(lk_valid && (!lk_hit || lk_memb == NONMEMB)));

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(cmd_busy)) |-> irq);

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_busy) |-> $past(cmd_go));

    // R6
    vid_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |-> $stable(vid_result));

    // R7
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_busy && !$past(cmd_busy)) |-> $stable(cmd_result));

    // R1
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_result[MISS_BIT] && cmd_result[MEMB_BIT]));

endmodule

bind vlan_viol_capture vvc_chk #(
    .MEMB_W        (MEMB_W),
    .NONMEMBER_CODE(NONMEMBER_CODE),
    .CMD_W         (CMD_W),
    .VID_W         (VID_W),
    .MISS_BIT      (MISS_BIT),
    .MEMB_BIT      (MEMB_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_memb   (lk_memb),
    .cmd_go    (cmd_go),
    .cmd_busy  (cmd_busy),
    .cmd_result(cmd_result),
    .vid_result(vid_result),
    .irq       (irq)
);

// File: tb/sim_vlan_viol_capture.sv
module sim_vlan_viol_capture;

    localparam int EXEC_CYCLES = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_hit, cmd_go;
    logic [3:0]  lk_port;
    logic [11:0] lk_vid;
    logic [1:0]  lk_memb;
    logic        cmd_busy, irq;
    logic [15:0] cmd_result;
    logic [11:0] vid_result;

    int checks = 0;
    int fails  = 0;

    // reference model of the held record
    bit          m_valid = 0;
    int          m_kind  = 0;   // 0 none, 1 miss, 2 member
    logic [3:0]  m_port  = '0;
    logic [11:0] m_vid   = '0;
    logic [11:0] m_vidreg = '0;

    always #10 clk = ~clk;

    vlan_viol_capture #(.EXEC_CYCLES(EXEC_CYCLES)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_port(lk_port),
        .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_memb(lk_memb), .cmd_go(cmd_go),
        .cmd_busy(cmd_busy), .cmd_result(cmd_result), .vid_result(vid_result),
        .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int kind_of(bit v, bit h, logic [1:0] m);
        if (!v) return 0;
        if (!h) return 1;
        if (m == 2'd3) return 2;
        return 0;
    endfunction

    function automatic logic [15:0] pack_exp();
        logic [15:0] r = '0;
        if (m_valid) begin
            r[3:0] = m_port;
            r[5]   = (m_kind == 1);
            r[6]   = (m_kind == 2);
        end
        return r;
    endfunction

    task automatic model_take(bit v, bit h, logic [1:0] m, logic [3:0] p, logic [11:0] vd);
        int k = kind_of(v, h, m);
        if (k != 0 && !m_valid) begin
            m_valid = 1; m_kind = k; m_port = p; m_vid = vd;
        end
    endtask

    task automatic lookup(string req, bit v, bit h, logic [1:0] m, logic [3:0] p, logic [11:0] vd);
        @(negedge clk);
        lk_valid = v; lk_hit = h; lk_memb = m; lk_port = p; lk_vid = vd;
        model_take(v, h, m, p, vd);
        @(negedge clk);
        lk_valid = 0;
        chk({req, " irq after lookup"}, 32'(irq), 32'(m_valid));
    endtask

    // mode 0 plain, 1 re-issue cmd_go while busy, 2 collide a miss in the report cycle
    task automatic get_clear(string req, int mode, logic [3:0] cp, logic [11:0] cv);
        logic [15:0] exp_res;
        logic [11:0] exp_vid;
        int n = 0;
        exp_res = pack_exp();
        exp_vid = m_valid ? m_vid : m_vidreg;
        @(negedge clk);
        cmd_go = 1;
        @(negedge clk);
        while (cmd_busy) begin
            n++;
            cmd_go = (mode == 1) && (n == 2);
            if (mode == 2 && n == EXEC_CYCLES + 1) begin
                lk_valid = 1; lk_hit = 0; lk_memb = 0; lk_port = cp; lk_vid = cv;
            end
            @(negedge clk);
            if (n > 50) break;
        end
        cmd_go = 0;
        lk_valid = 0;
        m_valid = 0;
        m_vidreg = exp_vid;
        if (mode == 2) model_take(1, 0, 2'd0, cp, cv);
        chk("R6 busy length", 32'(n), 32'(EXEC_CYCLES + 1));
        chk({req, " cmd_result"}, 32'(cmd_result), 32'(exp_res));
        chk({req, " vid_result"}, 32'(vid_result), 32'(exp_vid));
        chk("R5 irq after clear", 32'(irq), 32'(m_valid));
        if (mode == 1) begin
            @(negedge clk);
            chk("R8 no second command", 32'(cmd_busy), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        rst_n = 0; lk_valid = 0; lk_hit = 0; lk_memb = 0; lk_port = 0; lk_vid = 0; cmd_go = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11
        chk("R11 irq", 32'(irq), 0);
        chk("R11 busy", 32'(cmd_busy), 0);
        chk("R11 cmd_result", 32'(cmd_result), 0);
        chk("R11 vid_result", 32'(vid_result), 0);

        // R10: invalid lookup with miss-like inputs
        lookup("R10", 0, 0, 2'd3, 4'd7, 12'h0aa);
        // R3: member codes 0..2 on a hit
        for (int c = 0; c < 3; c++) lookup("R3", 1, 1, 2'(c), 4'd2, 12'h010);
        // R7 with nothing ever captured
        get_clear("R7 empty", 0, '0, '0);

        // R1 miss, then R4 a dropped member violation
        lookup("R1", 1, 0, 2'd0, 4'd5, 12'h123);
        lookup("R4", 1, 1, 2'd3, 4'd9, 12'h456);
        lookup("R4", 1, 0, 2'd0, 4'd1, 12'h789);
        get_clear("R1 R4", 0, '0, '0);
        // R7: VID result kept from previous report
        get_clear("R7 keep vid", 0, '0, '0);

        // R2 member violation with command re-issue (R8)
        lookup("R2", 1, 1, 2'd3, 4'd15, 12'hfff);
        get_clear("R2", 1, '0, '0);

        // R9 collision in report cycle
        lookup("R9", 1, 1, 2'd3, 4'd3, 12'h0c3);
        get_clear("R9 old record", 2, 4'd12, 12'h5a5);
        chk("R9 irq stays", 32'(irq), 1);
        get_clear("R9 new record", 0, '0, '0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 10 < 7)
                lookup("R1 R2 R3 R4 random", ($urandom % 8) != 0, ($urandom % 3) != 0,
                       2'($urandom % 4), 4'($urandom), 12'($urandom));
            else
                get_clear("R1 R2 R7 random", 0, '0, '0);
        end
        get_clear("R4 final", 0, '0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule